// File: doc/BRIEF.md
# Legacy Keyboard and Mouse Controller Channel

This block is the host-facing side of a keyboard and mouse controller in the classic 8042 style. The host sees two byte ports: a data port (I/O 60h) and a command/status port (I/O 64h). Decoded read and write strobes arrive with a single select bit that picks the port. Firmware sees a small register file. It can read the byte the host wrote, load a keyboard or a mouse byte for the host, read the status byte, set or clear its own status flags, and program the interrupt enables.

The block owns the two buffer handshakes. The input-buffer-full flag (IBF) rises on any host write and falls when firmware reads the input byte. The output-buffer-full flag (OBF) rises when firmware loads an output byte and falls when the host reads the data port. Firmware can also force OBF clear. A tag bit (A2) records whether the last host write went to the command port or to the data port. The keyboard host interrupt and the mouse host interrupt are separate level outputs. The block also has two core interrupts: one while IBF is set, and a one-cycle pulse when the host empties the output buffer.

Top module: `kbc8042_if`

## Requirements
- R1: After reset, the status byte reads 00h, the interrupt enable register reads 00h, and all four interrupt outputs are low.
- R2: A host write to either port sets IBF and stores the byte, which firmware reads at register 0. A2 becomes 1 for a write to the command port (hostAddrCmd=1) and 0 for a write to the data port. In the status byte, OBF is bit 0, IBF is bit 1 and A2 is bit 3.
- R3: A firmware read of register 0 clears IBF on the following clock. coreIbfIrq is high exactly while IBF is set and enable bit 0 of register 6 is set.
- R4: A firmware write to register 1 (keyboard output) sets OBF. irqKbd is then high, and stays high while OBF is set, if enable bit 2 is set. irqMouse stays low.
- R5: A firmware write to register 2 (mouse output) sets OBF. irqMouse is then high, and stays high while OBF is set, if enable bit 3 is set. irqKbd stays low.
- R6: A host read of the data port returns the last output byte and clears OBF, which drops the active host interrupt.
- R7: When a host data-port read clears OBF and enable bit 1 is set, coreObeIrq is high for exactly one cycle. With bit 1 clear it stays low.
- R8: Writing 1 to bit 4 of register 6 clears OBF in the status seen by both sides and produces no coreObeIrq pulse. Bit 4 reads back as 0, and the enable bits 3:0 written in the same access are kept.
- R9: A write to register 4 ORs its byte into the status flags, and a write to register 5 clears the flags at the positions of its 1 bits. Bits 0, 1 and 3 are never changed by either write.
- R10: A host read of the command/status port returns the status byte and leaves OBF and the host interrupts unchanged.
- R11: A host write in the same cycle as a firmware read of register 0 leaves IBF set, holding the new byte.
- R12: A firmware output write in the same cycle as a host data-port read leaves OBF set, holding the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostAddrCmd | input | 1 | Port select: 1 = command/status port, 0 = data port |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Host read byte (combinational) |
| fwWrEn | input | 1 | Firmware write strobe |
| fwRdEn | input | 1 | Firmware read strobe |
| fwAddr | input | 3 | Firmware register select |
| fwWrData | input | 8 | Firmware write byte |
| fwRdData | output | 8 | Firmware read byte (combinational) |
| irqKbd | output | 1 | Keyboard host interrupt, level, active high |
| irqMouse | output | 1 | Mouse host interrupt, level, active high |
| coreIbfIrq | output | 1 | Core interrupt, input buffer full (level) |
| coreObeIrq | output | 1 | Core interrupt, output buffer emptied (one-cycle pulse) |

## Verification
The bench goes after the collisions. In one, a host write meets a firmware input read in the same cycle; a design that lets the read win would lose the new command. In the other, a firmware output write meets a host data read in the same cycle; a design that lets the read win would drop OBF on a byte the host never saw. It checks that a force-clear produces no empty pulse, and that a status-port read does not consume the output byte; a design that got either wrong would raise a spurious core interrupt or lose keyboard data. It also writes all ones and then all zeros through the flag registers. This shows that the hardware-owned bits cannot be changed by firmware; a faulty mask would corrupt the handshake.

// File: rtl/kbc8042_pkg.sv
package kbc8042_pkg;
  localparam int BYTE_W    = 8;
  localparam int FW_ADDR_W = 3;

  localparam int OBF_BIT = 0;
  localparam int IBF_BIT = 1;
  localparam int A2_BIT  = 3;
  localparam logic [BYTE_W-1:0] HW_MASK =
    BYTE_W'((1 << OBF_BIT) | (1 << IBF_BIT) | (1 << A2_BIT));

  localparam int EN_IBF   = 0;
  localparam int EN_OBE   = 1;
  localparam int EN_KBD   = 2;
  localparam int EN_MOUSE = 3;
  localparam int EN_W     = 4;
  localparam int FCLR_BIT = 4;

  typedef enum logic [FW_ADDR_W-1:0] {
    FW_IN    = 3'd0,
    FW_KBD   = 3'd1,
    FW_MOUSE = 3'd2,
    FW_STAT  = 3'd3,
    FW_SETF  = 3'd4,
    FW_CLRF  = 3'd5,
    FW_CTL   = 3'd6
  } fwReg_e;

  typedef struct packed {
    logic loadIn;
    logic loadOut;
    logic setFlags;
    logic clrFlags;
    logic loadCtl;
  } dpStrb_t;
endpackage

// File: rtl/kbc8042_ctrl.sv
module kbc8042_ctrl
  import kbc8042_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostWr,
  input  logic                 hostRd,
  input  logic                 hostAddrCmd,
  input  logic                 fwWrEn,
  input  logic                 fwRdEn,
  input  logic [FW_ADDR_W-1:0] fwAddr,
  input  logic                 fwForceBit,
  input  logic [EN_W-1:0]      enables,
  output dpStrb_t              strb,
  output logic                 ibfQ,
  output logic                 obfQ,
  output logic                 a2Q,
  output logic                 irqKbd,
  output logic                 irqMouse,
  output logic                 coreIbfIrq,
  output logic                 coreObeIrq
);
  logic fwRdIn, fwWrKbd, fwWrMouse, fwWrCtl, hostRdDataPort, forceClr;
  logic srcMouseQ, obePulseQ;

  always_comb begin
    fwRdIn         = fwRdEn && (fwAddr == FW_IN);
    fwWrKbd        = fwWrEn && (fwAddr == FW_KBD);
    fwWrMouse      = fwWrEn && (fwAddr == FW_MOUSE);
    fwWrCtl        = fwWrEn && (fwAddr == FW_CTL);
    hostRdDataPort = hostRd && !hostAddrCmd;
    forceClr       = fwWrCtl && fwForceBit;

    strb.loadIn   = hostWr;
    strb.loadOut  = fwWrKbd || fwWrMouse;
    strb.setFlags = fwWrEn && (fwAddr == FW_SETF);
    strb.clrFlags = fwWrEn && (fwAddr == FW_CLRF);
    strb.loadCtl  = fwWrCtl;
  end

  // Input handshake: host write wins over firmware readout
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ibfQ <= 1'b0;
      a2Q  <= 1'b0;
    end else begin
      if (hostWr) begin
        ibfQ <= 1'b1;
        a2Q  <= hostAddrCmd;
      end else if (fwRdIn) begin
        ibfQ <= 1'b0;
      end
    end
  end

  // Output handshake: firmware load wins over host read and force clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      obfQ      <= 1'b0;
      srcMouseQ <= 1'b0;
      obePulseQ <= 1'b0;
    end else begin
      obePulseQ <= enables[EN_OBE] && hostRdDataPort && obfQ &&
                   !strb.loadOut && !forceClr;
      if (strb.loadOut) begin
        obfQ      <= 1'b1;
        srcMouseQ <= fwWrMouse;
      end else if (hostRdDataPort || forceClr) begin
        obfQ <= 1'b0;
      end
    end
  end

  always_comb begin
    irqKbd     = obfQ && !srcMouseQ && enables[EN_KBD];
    irqMouse   = obfQ &&  srcMouseQ && enables[EN_MOUSE];
    coreIbfIrq = ibfQ && enables[EN_IBF];
    coreObeIrq = obePulseQ;
  end

  assert_ibf_irq_R3: assert property (@(posedge clk) disable iff (!rstN)
    coreIbfIrq |-> ibfQ);
  assert_irq_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(irqKbd && irqMouse));
  assert_host_irq_level_R6: assert property (@(posedge clk) disable iff (!rstN)
    (irqKbd || irqMouse) |-> obfQ);
  assert_obe_after_fall_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreObeIrq) |-> (!obfQ && $past(obfQ)));
  assert_force_no_obe_R8: assert property (@(posedge clk) disable iff (!rstN)
    (forceClr && !hostRd) |=> !coreObeIrq);
  assert_flags_keep_ibf_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.setFlags || strb.clrFlags) && !hostWr && !fwRdIn) |=> $stable(ibfQ));
  assert_collide_in_R11: assert property (@(posedge clk) disable iff (!rstN)
    hostWr |=> ibfQ);
  assert_collide_out_R12: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadOut |=> obfQ);
endmodule

// File: rtl/kbc8042_dp.sv
module kbc8042_dp
  import kbc8042_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrb_t              strb,
  input  logic [BYTE_W-1:0]    hostWrData,
  input  logic                 hostAddrCmd,
  input  logic [FW_ADDR_W-1:0] fwAddr,
  input  logic [BYTE_W-1:0]    fwWrData,
  input  logic                 ibfQ,
  input  logic                 obfQ,
  input  logic                 a2Q,
  output logic [EN_W-1:0]      enables,
  output logic [BYTE_W-1:0]    hostRdData,
  output logic [BYTE_W-1:0]    fwRdData
);
  logic [BYTE_W-1:0] inDataQ, outDataQ, flagsQ, statusByte;
  logic [EN_W-1:0]   ctlQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inDataQ  <= '0;
      outDataQ <= '0;
      flagsQ   <= '0;
      ctlQ     <= '0;
    end else begin
      if (strb.loadIn)   inDataQ  <= hostWrData;
      if (strb.loadOut)  outDataQ <= fwWrData;
      if (strb.setFlags) flagsQ   <= flagsQ | (fwWrData & ~HW_MASK);
      if (strb.clrFlags) flagsQ   <= flagsQ & ~(fwWrData & ~HW_MASK);
      if (strb.loadCtl)  ctlQ     <= fwWrData[EN_W-1:0];
    end
  end

  always_comb begin
    statusByte          = flagsQ & ~HW_MASK;
    statusByte[OBF_BIT] = obfQ;
    statusByte[IBF_BIT] = ibfQ;
    statusByte[A2_BIT]  = a2Q;
    enables             = ctlQ;
    hostRdData          = hostAddrCmd ? statusByte : outDataQ;
    case (fwAddr)
      FW_IN:   fwRdData = inDataQ;
      FW_STAT: fwRdData = statusByte;
      FW_CTL:  fwRdData = {{(BYTE_W-EN_W){1'b0}}, ctlQ};
      default: fwRdData = '0;
    endcase
  end

  assert_flag_mask_R9: assert property (@(posedge clk) disable iff (!rstN)
    (flagsQ & HW_MASK) == '0);
  assert_in_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadIn |=> (inDataQ == $past(hostWrData)));
endmodule

// File: rtl/kbc8042_if.sv
module kbc8042_if
  import kbc8042_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostWr,
  input  logic                 hostRd,
  input  logic                 hostAddrCmd,
  input  logic [BYTE_W-1:0]    hostWrData,
  output logic [BYTE_W-1:0]    hostRdData,
  input  logic                 fwWrEn,
  input  logic                 fwRdEn,
  input  logic [FW_ADDR_W-1:0] fwAddr,
  input  logic [BYTE_W-1:0]    fwWrData,
  output logic [BYTE_W-1:0]    fwRdData,
  output logic                 irqKbd,
  output logic                 irqMouse,
  output logic                 coreIbfIrq,
  output logic                 coreObeIrq
);
  dpStrb_t         strb;
  logic            ibfQ, obfQ, a2Q;
  logic [EN_W-1:0] enables;

  kbc8042_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd),
    .hostAddrCmd(hostAddrCmd), .fwWrEn(fwWrEn), .fwRdEn(fwRdEn),
    .fwAddr(fwAddr), .fwForceBit(fwWrData[FCLR_BIT]), .enables(enables),
    .strb(strb), .ibfQ(ibfQ), .obfQ(obfQ), .a2Q(a2Q), .irqKbd(irqKbd),
    .irqMouse(irqMouse), .coreIbfIrq(coreIbfIrq), .coreObeIrq(coreObeIrq)
  );

  kbc8042_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .hostWrData(hostWrData),
    .hostAddrCmd(hostAddrCmd), .fwAddr(fwAddr), .fwWrData(fwWrData),
    .ibfQ(ibfQ), .obfQ(obfQ), .a2Q(a2Q), .enables(enables),
    .hostRdData(hostRdData), .fwRdData(fwRdData)
  );
endmodule

// File: tb/kbc8042_if_tb.sv
module kbc8042_if_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWr = 0, hostRd = 0, hostAddrCmd = 0;
  logic [7:0] hostWrData = 0, hostRdData;
  logic fwWrEn = 0, fwRdEn = 0;
  logic [2:0] fwAddr = 0;
  logic [7:0] fwWrData = 0, fwRdData;
  logic irqKbd, irqMouse, coreIbfIrq, coreObeIrq;
  int checks = 0, errors = 0;
  logic [7:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbc8042_if u_dut (.*);

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(logic cmd, logic [7:0] d);
    @(negedge clk); hostWr = 1; hostAddrCmd = cmd; hostWrData = d;
    @(negedge clk); hostWr = 0;
  endtask

  task automatic hostRead(logic cmd, output logic [7:0] d);
    @(negedge clk); hostRd = 1; hostAddrCmd = cmd;
    #1 d = hostRdData;
    @(negedge clk); hostRd = 0;
  endtask

  task automatic fwWrite(logic [2:0] a, logic [7:0] d);
    @(negedge clk); fwWrEn = 1; fwAddr = a; fwWrData = d;
    @(negedge clk); fwWrEn = 0; fwWrData = 0;
  endtask

  task automatic fwRead(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); fwRdEn = 1; fwAddr = a;
    #1 d = fwRdData;
    @(negedge clk); fwRdEn = 0;
  endtask

  task automatic t_reset();
    fwRead(3, v); check("R1 status", v, 8'h00);
    fwRead(6, v); check("R1 enables", v, 8'h00);
    check("R1 irqs", {4'h0, irqKbd, irqMouse, coreIbfIrq, coreObeIrq}, 8'h00);
  endtask

  task automatic t_input();
    fwWrite(6, 8'h01);
    hostWrite(0, 8'h5A);
    fwRead(3, v); check("R2 status after data write", v, 8'h02);
    check("R3 ibf irq set", {7'h0, coreIbfIrq}, 8'h01);
    hostRead(1, v); check("R2 host status", v, 8'h02);
    fwRead(0, v); check("R2 input byte", v, 8'h5A);
    fwRead(3, v); check("R3 ibf cleared", v, 8'h00);
    check("R3 ibf irq clear", {7'h0, coreIbfIrq}, 8'h00);
    hostWrite(1, 8'hD4);
    fwRead(3, v); check("R2 status after cmd write", v, 8'h0A);
    fwRead(0, v); check("R2 cmd byte", v, 8'hD4);
    hostWrite(0, 8'h01);
    fwRead(0, v);
    fwRead(3, v); check("R2 A2 back to 0", v, 8'h00);
  endtask

  task automatic t_kbd();
    fwWrite(6, 8'h0F);
    fwWrite(1, 8'h1C);
    check("R4 irqKbd/irqMouse", {6'h0, irqKbd, irqMouse}, 8'h02);
    fwRead(3, v); check("R4 OBF set", v, 8'h01);
    hostRead(0, v); check("R6 host data byte", v, 8'h1C);
    check("R7 obe pulse", {7'h0, coreObeIrq}, 8'h01);
    check("R6 irqKbd dropped", {7'h0, irqKbd}, 8'h00);
    @(negedge clk);
    check("R7 obe pulse one cycle", {7'h0, coreObeIrq}, 8'h00);
    fwRead(3, v); check("R6 OBF cleared", v, 8'h00);
  endtask

  task automatic t_mouse();
    fwWrite(2, 8'h77);
    check("R5 irqMouse/irqKbd", {6'h0, irqKbd, irqMouse}, 8'h01);
    hostRead(1, v); check("R10 status read", v, 8'h01);
    check("R10 irqMouse kept", {7'h0, irqMouse}, 8'h01);
    hostRead(0, v); check("R6 mouse byte", v, 8'h77);
    check("R6 irqMouse dropped", {7'h0, irqMouse}, 8'h00);
  endtask

  task automatic t_disabled();
    fwWrite(6, 8'h01);
    fwWrite(1, 8'h42);
    check("R4 irqKbd gated", {7'h0, irqKbd}, 8'h00);
    fwRead(3, v); check("R4 OBF set while gated", v, 8'h01);
    hostRead(0, v);
    check("R7 no obe when disabled", {7'h0, coreObeIrq}, 8'h00);
  endtask

  task automatic t_force();
    fwWrite(6, 8'h0F);
    fwWrite(1, 8'h33);
    fwWrite(6, 8'h1F);
    check("R8 no obe on force", {7'h0, coreObeIrq}, 8'h00);
    check("R8 irqKbd dropped", {7'h0, irqKbd}, 8'h00);
    @(negedge clk);
    check("R8 no obe later", {7'h0, coreObeIrq}, 8'h00);
    fwRead(3, v); check("R8 fw OBF clear", v, 8'h00);
    hostRead(1, v); check("R8 host OBF clear", v, 8'h00);
    fwRead(6, v); check("R8 ctl readback", v, 8'h0F);
  endtask

  task automatic t_flags();
    fwWrite(4, 8'hFF);
    fwRead(3, v); check("R9 set masked", v, 8'hF4);
    fwWrite(1, 8'h10);
    hostWrite(1, 8'hAA);
    fwWrite(5, 8'hFF);
    fwRead(3, v); check("R9 clear masked", v, 8'h0B);
    hostRead(0, v);
    fwRead(0, v);
    fwRead(3, v); check("R9 handshake restored", v, 8'h08);
  endtask

  task automatic t_collide_in();
    hostWrite(0, 8'h44);
    @(negedge clk);
    hostWr = 1; hostAddrCmd = 0; hostWrData = 8'h33; fwRdEn = 1; fwAddr = 0;
    @(negedge clk); hostWr = 0; fwRdEn = 0;
    fwRead(3, v); check("R11 IBF kept", v & 8'h02, 8'h02);
    fwRead(0, v); check("R11 new byte", v, 8'h33);
  endtask

  task automatic t_collide_out();
    fwWrite(1, 8'h11);
    @(negedge clk);
    fwWrEn = 1; fwAddr = 1; fwWrData = 8'h22; hostRd = 1; hostAddrCmd = 0;
    @(negedge clk); fwWrEn = 0; hostRd = 0;
    fwRead(3, v); check("R12 OBF kept", v & 8'h01, 8'h01);
    hostRead(0, v); check("R12 new byte", v, 8'h22);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_input();
    t_kbd();
    t_mouse();
    t_disabled();
    t_force();
    t_flags();
    t_collide_in();
    t_collide_out();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule